// File: doc/BRIEF.md
# LFSR Free-Run Self-Test Checker

This block checks the deterministic core of a random-number source that has been run with every noise input switched off. With no entropy present, the source's 64-bit LFSR runs freely. A diagnostic word read from it must therefore equal a predictable LFSR state. Software or a capture engine loads a short list of such words through a valid/data port, then pulses start. The checker replays a model of the LFSR from a known seed and looks for one window offset at which enough of the captured words agree with the model.

The real reads are not exactly on time. A read can come one free-running cycle early or several hundred cycles late. For that reason the model begins one step before the nominal sample instant and is advanced one step per tried offset. The first captured word is never used, because the delay before it is unknown. One stray word is tolerated. The block runs one comparison per clock, stops as soon as an offset collects enough agreements, and reports the outcome with a one-cycle done pulse that carries either pass or fail.

Top module: `lfsr_freerun_check`

## Requirements
- R1: While reset is high and after it is released, done_o, pass_o and fail_o are all 0 until a scan completes.
- R2: The model starts at seed 0xb8820c7bd387e32c. A step shifts the 64-bit state left by one bit, and XORs in the polynomial 0x231dcee91262b8a3 when the bit shifted out of bit 63 was 1. A word matches at offset k when it equals the seed after k steps.
- R3: Offsets 0 through WINDOW (default 400) inclusive are tried. Words that match only at offset WINDOW+1 do not pass.
- R4: Buffered word 0 never takes part in the comparison. Its value has no effect on the result.
- R5: An offset passes when at most MAX_MISS (default 1) of words 1..N_WORDS-1 differ from the model. Two mismatching words at every offset give fail.
- R6: One word is compared per clock, in index order 1..N_WORDS-1, for offsets in increasing order. done_o and pass_o rise together k*(N_WORDS-1)+j clock edges after the start edge, where k is the passing offset and j is the word index at which the agreement count first reaches N_WORDS-1-MAX_MISS.
- R7: When no offset passes, done_o and fail_o rise together exactly (WINDOW+1)*(N_WORDS-1) clock edges after the start edge (2807 at defaults).
- R8: done_o is high for exactly one cycle, and when it is high exactly one of pass_o and fail_o is high. Neither is high without done_o.
- R9: Loaded words fill buffer indices 0,1,2,... in arrival order, starting from 0 after each start. Loads beyond N_WORDS words, and loads while a scan runs, are ignored.
- R10: A start pulse at any time, including mid-scan, restarts the scan from offset 0 with the seed. The next done_o cannot occur on the cycle right after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins (or restarts) a scan |
| load_valid_i | input | 1 | Writes load_data_i to the next buffer slot |
| load_data_i | input | 64 | Captured diagnostic word |
| done_o | output | 1 | One-cycle pulse when a scan finishes |
| pass_o | output | 1 | High with done_o when an offset matched |
| fail_o | output | 1 | High with done_o when the window ran out |

## Verification
The word sets used are:
- all words at offset 0 (early read);
- all words at the last window offset, and at one offset past the window;
- a junk first word;
- one junk word, and two junk words;
- each word at its own offset, which should never pass;
- surplus loads and loads issued during a scan;
- a restart in mid-scan.

The pass cases tell apart a correct seed, step function and window bound from off-by-one variants, because each expected done cycle is computed from the offset and the index at which the threshold is met. The fail cases confirm the full window length and the mismatch limit.

// File: rtl/lfsr_freerun_pkg.sv
package lfsr_freerun_pkg;

    localparam int WORD_W = 64;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    // One free-running step of the generator modulo x^64 + poly.
    function automatic word_t lfsr_advance(input word_t cur, input word_t poly);
        word_t shifted;
        shifted = {cur[WORD_W-2:0], 1'b0};
        return cur[WORD_W-1] ? (shifted ^ poly) : shifted;
    endfunction

endpackage

// File: rtl/lfsr_freerun_buf.sv
module lfsr_freerun_buf
    import lfsr_freerun_pkg::*;
#(
    parameter int N_WORDS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       wr_en,
    input  word_t                      wr_data,
    input  logic [$clog2(N_WORDS)-1:0] rd_idx,
    output word_t                      rd_data
);
    localparam int PW = $clog2(N_WORDS + 1);

    logic [PW-1:0] fill_q;
    word_t         slot_q [N_WORDS];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill_q <= '0;
        end else if (wr_en && (fill_q < PW'(N_WORDS))) begin
            fill_q <= fill_q + PW'(1);
        end
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!clr && wr_en && (fill_q == PW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/lfsr_freerun_model.sv
module lfsr_freerun_model
    import lfsr_freerun_pkg::*;
#(
    parameter word_t SEED = 64'hb8820c7bd387e32c,
    parameter word_t POLY = 64'h231dcee91262b8a3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  seed_load,
    input  logic  step,
    output word_t state_o
);
    word_t state_q;

    always_ff @(posedge clk) begin
        if (rst || seed_load) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= lfsr_advance(state_q, POLY);
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/lfsr_freerun_ctrl.sv
module lfsr_freerun_ctrl
    import lfsr_freerun_pkg::*;
#(
    parameter int N_WORDS  = 8,
    parameter int WINDOW   = 400,
    parameter int MAX_MISS = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic                       hit,
    output logic [$clog2(N_WORDS)-1:0] rd_idx,
    output logic                       step,
    output logic                       scanning,
    output logic                       done,
    output logic                       pass,
    output logic                       fail
);
    localparam int IW     = $clog2(N_WORDS);
    localparam int OW     = $clog2(WINDOW + 1);
    localparam int CW     = $clog2(N_WORDS) + 1;
    localparam int THRESH = N_WORDS - 1 - MAX_MISS;

    scan_state_e   state_q;
    logic [IW-1:0] idx_q;
    logic [OW-1:0] off_q;
    logic [CW-1:0] agree_q;
    logic [CW-1:0] agree_nx;
    logic          reach, row_end, last_off;

    always_comb begin
        agree_nx = agree_q + CW'(hit);
        reach    = agree_nx >= CW'(THRESH);
        row_end  = idx_q == IW'(N_WORDS - 1);
        last_off = off_q == OW'(WINDOW);
        step     = (state_q == ST_SCAN) && !start && !reach && row_end && !last_off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= IW'(1);
            off_q   <= '0;
            agree_q <= '0;
            done    <= 1'b0;
            pass    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            done <= 1'b0;
            pass <= 1'b0;
            fail <= 1'b0;
            if (start) begin
                state_q <= ST_SCAN;
                idx_q   <= IW'(1);
                off_q   <= '0;
                agree_q <= '0;
            end else if (state_q == ST_SCAN) begin
                if (reach) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                    pass    <= 1'b1;
                end else if (row_end) begin
                    if (last_off) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                        fail    <= 1'b1;
                    end else begin
                        off_q   <= off_q + OW'(1);
                        idx_q   <= IW'(1);
                        agree_q <= '0;
                    end
                end else begin
                    idx_q   <= idx_q + IW'(1);
                    agree_q <= agree_nx;
                end
            end
        end
    end

    assign rd_idx   = idx_q;
    assign scanning = state_q == ST_SCAN;

endmodule

// File: rtl/lfsr_freerun_check.sv
module lfsr_freerun_check
    import lfsr_freerun_pkg::*;
#(
    parameter int    N_WORDS  = 8,
    parameter int    WINDOW   = 400,
    parameter int    MAX_MISS = 1,
    parameter word_t SEED     = 64'hb8820c7bd387e32c,
    parameter word_t POLY     = 64'h231dcee91262b8a3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        load_valid_i,
    input  logic [63:0] load_data_i,
    output logic        done_o,
    output logic        pass_o,
    output logic        fail_o
);
    localparam int IW = $clog2(N_WORDS);

    logic [IW-1:0] rd_idx;
    word_t         buf_word;
    word_t         model_word;
    logic          step, scanning;

    lfsr_freerun_buf #(.N_WORDS(N_WORDS)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .clr     (start_i),
        .wr_en   (load_valid_i && !scanning),
        .wr_data (load_data_i),
        .rd_idx  (rd_idx),
        .rd_data (buf_word)
    );

    lfsr_freerun_model #(.SEED(SEED), .POLY(POLY)) u_model (
        .clk       (clk),
        .rst       (rst),
        .seed_load (start_i),
        .step      (step),
        .state_o   (model_word)
    );

    lfsr_freerun_ctrl #(
        .N_WORDS  (N_WORDS),
        .WINDOW   (WINDOW),
        .MAX_MISS (MAX_MISS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .hit      (buf_word == model_word),
        .rd_idx   (rd_idx),
        .step     (step),
        .scanning (scanning),
        .done     (done_o),
        .pass     (pass_o),
        .fail     (fail_o)
    );

endmodule

// File: rtl/lfsr_freerun_check_sva.sv
module lfsr_freerun_check_sva #(
    parameter int N_WORDS = 8,
    parameter int WINDOW  = 400
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic done_o,
    input logic pass_o,
    input logic fail_o
);
    localparam int FAIL_LAT = (WINDOW + 1) * (N_WORDS - 1);

    logic [31:0] since_start;

    always_ff @(posedge clk) begin
        if (rst || start_i) since_start <= '0;
        else                since_start <= since_start + 32'd1;
    end

    assert_verdict_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $countones({pass_o, fail_o}) == 1);

    assert_verdict_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        (pass_o || fail_o) |-> done_o);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_fail_at_window_end_R7: assert property (@(posedge clk) disable iff (rst)
        fail_o |-> since_start == FAIL_LAT);

    assert_pass_inside_window_R6: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> since_start < FAIL_LAT);

    assert_start_quiets_done_R10: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !done_o);

endmodule

bind lfsr_freerun_check lfsr_freerun_check_sva #(
    .N_WORDS (N_WORDS),
    .WINDOW  (WINDOW)
) u_sva (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .done_o  (done_o),
    .pass_o  (pass_o),
    .fail_o  (fail_o)
);

// File: tb/tb_lfsr_freerun_check.sv
module tb_lfsr_freerun_check;

    localparam int  NW       = 8;
    localparam int  WIN      = 400;
    localparam int  FAIL_LAT = (WIN + 1) * (NW - 1);
    localparam logic [63:0] SEED = 64'hb8820c7bd387e32c;
    localparam logic [63:0] POLY = 64'h231dcee91262b8a3;
    localparam logic [63:0] JUNK = 64'h5a5a_0123_fedc_a987;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        load_valid_i = 1'b0;
    logic [63:0] load_data_i = '0;
    logic        done_o, pass_o, fail_o;

    typedef struct {
        bit    exp_pass;
        int    exp_lat;
        string tag;
    } exp_t;

    exp_t        sbq [$];
    int          checks = 0;
    int          errors = 0;
    int          n_done = 0;
    int          cyc = 0;
    bit          prev_done = 0;
    logic [63:0] pat [NW];

    always #4 clk = ~clk;

    lfsr_freerun_check dut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .load_valid_i (load_valid_i),
        .load_data_i  (load_data_i),
        .done_o       (done_o),
        .pass_o       (pass_o),
        .fail_o       (fail_o)
    );

    // R2: state after k steps from the seed
    function automatic logic [63:0] model_at(input int k);
        logic [63:0] s = SEED;
        for (int i = 0; i < k; i++) begin
            s = s[63] ? ({s[62:0], 1'b0} ^ POLY) : {s[62:0], 1'b0};
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill_all(input int k);
        for (int i = 0; i < NW; i++) pat[i] = model_at(k);
    endtask

    task automatic load_pat(input int n_extra);
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            load_valid_i = 1'b1;
            load_data_i  = pat[i];
        end
        for (int i = 0; i < n_extra; i++) begin
            @(negedge clk);
            load_valid_i = 1'b1;
            load_data_i  = JUNK;
        end
        @(negedge clk);
        load_valid_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_case(input int n_extra, input bit junk_in_scan,
                            input bit exp_pass, input int exp_lat, input string tag);
        int d0;
        exp_t e;
        load_pat(n_extra);
        e.exp_pass = exp_pass;
        e.exp_lat  = exp_lat;
        e.tag      = tag;
        sbq.push_back(e);
        d0 = n_done;
        pulse_start();
        if (junk_in_scan) begin
            for (int i = 0; i < 3; i++) begin
                load_valid_i = 1'b1;
                load_data_i  = JUNK;
                @(negedge clk);
            end
            load_valid_i = 1'b0;
        end
        while (n_done == d0) @(posedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expectations when a verdict appears
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                cyc = 0;
                prev_done = 0;
            end else begin
                if (start_i) cyc = 0;
                else         cyc++;
                if (prev_done) chk(!done_o, "R8 done pulse width", done_o, 0);
                if (done_o) begin
                    if (sbq.size() == 0) begin
                        chk(0, "R8 unexpected done", 1, 0);
                    end else begin
                        e = sbq.pop_front();
                        chk(pass_o == e.exp_pass, {e.tag, " pass_o"}, pass_o, e.exp_pass);
                        chk(fail_o == !e.exp_pass, {e.tag, " fail_o"}, fail_o, !e.exp_pass);
                        chk(cyc == e.exp_lat, {e.tag, " latency"}, cyc, e.exp_lat);
                    end
                    n_done++;
                end
                prev_done = done_o;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(!done_o && !pass_o && !fail_o, "R1 outputs in reset", {done_o, pass_o, fail_o}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done_o && !pass_o && !fail_o, "R1 outputs after reset", {done_o, pass_o, fail_o}, 0);

        // R2/R6: early read, offset 0 = seed itself
        fill_all(0);
        run_case(0, 0, 1'b1, 6, "R2 R6 offset0");

        // R3: last window offset passes, one beyond fails
        fill_all(WIN);
        run_case(0, 0, 1'b1, WIN * (NW - 1) + 6, "R3 offset400");
        fill_all(WIN + 1);
        run_case(0, 0, 1'b0, FAIL_LAT, "R3 R7 offset401");

        // R4: word 0 is not compared
        fill_all(37);
        pat[0] = JUNK;
        run_case(0, 0, 1'b1, 37 * (NW - 1) + 6, "R4 junk word0");

        // R5: one mismatch tolerated (threshold reached at index 7)
        fill_all(5);
        pat[1] = JUNK;
        run_case(0, 0, 1'b1, 5 * (NW - 1) + 7, "R5 R6 one miss");

        // R5: two mismatches fail
        fill_all(5);
        pat[2] = JUNK;
        pat[5] = JUNK;
        run_case(0, 0, 1'b0, FAIL_LAT, "R5 R7 two miss");

        // R2: each word at its own offset never gathers enough agreement
        for (int i = 0; i < NW; i++) pat[i] = model_at(10 + i);
        run_case(0, 0, 1'b0, FAIL_LAT, "R2 mixed offsets");

        // R9: loads during a scan are ignored
        fill_all(3);
        run_case(0, 1, 1'b1, 3 * (NW - 1) + 6, "R9 load during scan");

        // R9: surplus loads beyond N_WORDS are ignored
        fill_all(9);
        run_case(3, 0, 1'b1, 9 * (NW - 1) + 6, "R9 surplus loads");

        // R10: restart in mid-scan, latency counts from the second start
        begin
            int d0;
            exp_t e;
            fill_all(5);
            pat[3] = JUNK;
            pat[6] = JUNK;
            load_pat(0);
            pulse_start();
            repeat (500) @(negedge clk);
            chk(n_done == 0 || !done_o, "R10 no verdict mid-scan", done_o, 0);
            e.exp_pass = 1'b0;
            e.exp_lat  = FAIL_LAT;
            e.tag      = "R10 restart";
            sbq.push_back(e);
            d0 = n_done;
            pulse_start();
            while (n_done == d0) @(posedge clk);
            repeat (3) @(negedge clk);
        end

        chk(sbq.size() == 0, "R8 all verdicts seen", sbq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule